// File: doc/BRIEF.md
# Half-Spectrum Magnitude Serial Sender

This block sits behind a transform core that produces one frame of complex bins at a time. It captures every bin of the frame, real and imaginary parts in separate storage, along with the block exponent that the core gives once for the whole frame. When the closing beat of the frame has been stored, the block starts sending at once over a single serial line. Because the samples fed to the transform are real, the upper half of the spectrum mirrors the lower half. Only bins 0 through `SEND_BINS-1` are sent. With the defaults that is 601 of 1200 stored bins, and the last one sent is the centre bin.

For each bin the block computes the integer magnitude floor(sqrt(re² + im²)) and clips it to 12 bits. It sends the result as a 16-bit word: the high byte goes first and carries zeros in its upper nibble. The host reads the 12 bits as unsigned fixed point, with bit 11 the single integer bit and bits 10:0 the fraction. A frame opens with one exponent byte and then carries two bytes per bin, so the default frame is 1203 characters. The square root is a pipeline that takes one result bit per stage. It runs while the previous characters are still on the line, so the characters leave back to back.

`busy` is high from the acceptance of the closing beat until the line has gone idle. Transform beats that arrive while `busy` is high are dropped. `CLKS_PER_BIT` sets the bit time; the default of 67 suits a 200 MHz clock and about 3 Mbit/s. Ten bit times must exceed the root latency of about `DATA_W+4` cycles.

Top module: `spec_mag_sender`

## Requirements
- R1: While reset is applied and after its release, `tx` is high and `busy` is low until a frame has been collected.
- R2: A beat is stored when `xf_valid` is high and `busy` is low, in arrival order, and cycles with `xf_valid` low are skipped. `xf_exp` is sampled only on the beat that has `xf_last` high, and `busy` is high in the cycle after that beat.
- R3: Beats presented while `busy` is high, including one with `xf_last` set, change neither the frame being sent nor the stored exponent, and they do not start a further frame.
- R4: The start bit of the first character begins no more than 4 clock cycles after the clock edge that accepts the closing beat.
- R5: The first character of a frame is the exponent byte: zeros in bits 7:4 and the block exponent in bits 3:0.
- R6: After the exponent byte, each bin k from 0 upward is sent as two characters. The first is {4'b0000, m[11:8]} and the second is m[7:0], where m = floor(sqrt(re² + im²)) and re, im are two's complement. When the root exceeds 4095, m is 4095.
- R7: Each character is one low start bit, then 8 data bits LSB first, then one high stop bit. Every bit lasts exactly `CLKS_PER_BIT` clock cycles.
- R8: All characters of a frame follow one another with no idle time. Each new start bit begins in the cycle right after the previous stop bit ends.
- R9: `busy` stays high for the whole frame on the line and is low no later than the second cycle after the final stop bit. `tx` is high whenever no character is being sent.
- R10: Exactly 1 + 2·`SEND_BINS` characters are sent per frame. Bins from `SEND_BINS` upward are stored but never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts at once, releases synchronously |
| xf_valid | input | 1 | Transform output beat is present |
| xf_last | input | 1 | Beat closes the frame |
| xf_re | input | DATA_W | Real part, two's complement |
| xf_im | input | DATA_W | Imaginary part, two's complement |
| xf_exp | input | EXP_W | Block exponent, valid with the closing beat |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame held and being sent; input beats are dropped |

## Verification
The crowded cycle is the final stop-bit cycle of one character. In that same cycle the sequencer hands over the next byte, and the magnitude for the following bin may be arriving from the root pipeline. Every character boundary of every frame provokes this. The bench judges it by comparing the line to an ideal continuous waveform on every clock, so a single idle cycle or a shifted bit is reported. A second overlap is input beats, one with a closing flag among them, driven while a frame is on the line. The bench judges this by the unaltered waveform and by the absence of any extra frame afterwards.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic {CT_IDLE, CT_SEND} ctrl_state_e;
  typedef enum logic [1:0] {PH_EXP, PH_HI, PH_LO, PH_END} tx_phase_e;
  localparam int CHAR_W = 8;
endpackage

// File: rtl/spm_frame_store.sv
module spm_frame_store #(
  parameter int DEPTH  = 1200,
  parameter int DATA_W = 16,
  parameter int EXP_W  = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic              release_i,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_re,
  output logic [DATA_W-1:0] rd_im,
  output logic              rd_valid,
  output logic [EXP_W-1:0]  exp_q,
  output logic              full
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [DATA_W-1:0] mem_re [DEPTH];
  logic [DATA_W-1:0] mem_im [DEPTH];
  logic [PW-1:0]     wr_q, wr_d;
  logic              full_q, full_d;
  logic [EXP_W-1:0]  exp_d;
  logic              accept, we;

  always_comb begin
    accept = in_valid && !full_q;
    we     = accept && (wr_q < DEPTH_P);
    wr_d   = wr_q;
    full_d = full_q;
    exp_d  = exp_q;
    if (accept) begin
      if (in_last) begin
        wr_d   = '0;
        full_d = 1'b1;
        exp_d  = in_exp;
      end else if (wr_q < DEPTH_P) begin
        wr_d = wr_q + PW'(1);
      end
    end
    if (release_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      full_q <= 1'b0;
      exp_q  <= '0;
    end else begin
      wr_q   <= wr_d;
      full_q <= full_d;
      exp_q  <= exp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem_re[wr_q[AW-1:0]] <= in_re;
      mem_im[wr_q[AW-1:0]] <= in_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_re    <= '0;
      rd_im    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_re <= mem_re[rd_addr];
        rd_im <= mem_im[rd_addr];
      end
    end
  end

  assign full = full_q;

  // R3: a held frame is not disturbed by further beats
  assert_hold_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && in_valid && !release_i) |=> ($stable(wr_q) && $stable(exp_q)));
endmodule

// File: rtl/spm_isqrt.sv
module spm_isqrt #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_re,
  input  logic signed [IN_W-1:0] in_im,
  output logic                   out_valid,
  output logic [OUT_W-1:0]       out_mag
);
  localparam int SUM_W  = 2 * IN_W + 2;
  localparam int ROOT_W = IN_W + 1;
  localparam int RW     = ROOT_W + 2;
  localparam int NST    = ROOT_W;
  localparam logic [ROOT_W-1:0] MAG_MAX = ROOT_W'((2 ** OUT_W) - 1);

  logic signed [2*IN_W-1:0] sq_re, sq_im;
  logic [SUM_W-1:0]  sum_w;
  logic [SUM_W-1:0]  v_q [NST];
  logic [SUM_W-1:0]  v_d [NST];
  logic [RW-1:0]     r_q [NST];
  logic [RW-1:0]     r_d [NST];
  logic [ROOT_W-1:0] q_q [NST+1];
  logic [ROOT_W-1:0] q_d [NST+1];
  logic [RW-1:0]     rs_w [NST];
  logic [RW-1:0]     tr_w [NST];
  logic [NST-1:0]    ge_w;
  logic [NST:0]      vld_q, vld_d;

  always_comb begin
    sq_re = (2*IN_W)'(in_re) * (2*IN_W)'(in_re);
    sq_im = (2*IN_W)'(in_im) * (2*IN_W)'(in_im);
    sum_w = SUM_W'($unsigned(sq_re)) + SUM_W'($unsigned(sq_im));
    v_d[0]   = sum_w;
    r_d[0]   = '0;
    q_d[0]   = '0;
    vld_d[0] = in_valid;
    for (int k = 0; k < NST; k++) begin
      rs_w[k]    = (r_q[k] << 2) | RW'(v_q[k][SUM_W-1 -: 2]);
      tr_w[k]    = {q_q[k], 2'b01};
      ge_w[k]    = rs_w[k] >= tr_w[k];
      q_d[k+1]   = {q_q[k][ROOT_W-2:0], ge_w[k]};
      vld_d[k+1] = vld_q[k];
    end
    for (int k = 0; k < NST - 1; k++) begin
      r_d[k+1] = ge_w[k] ? (rs_w[k] - tr_w[k]) : rs_w[k];
      v_d[k+1] = v_q[k] << 2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int k = 0; k < NST; k++) begin
        v_q[k] <= '0;
        r_q[k] <= '0;
      end
      for (int k = 0; k <= NST; k++) q_q[k] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int k = 0; k < NST; k++) begin
        if (vld_d[k]) begin
          v_q[k] <= v_d[k];
          r_q[k] <= r_d[k];
          q_q[k] <= q_d[k];
        end
      end
      if (vld_d[NST]) q_q[NST] <= q_d[NST];
    end
  end

  assign out_valid = vld_q[NST];
  assign out_mag   = (q_q[NST] > MAG_MAX) ? '1 : q_q[NST][OUT_W-1:0];
endmodule

// File: rtl/spm_uart_tx.sv
module spm_uart_tx #(
  parameter int CLKS_PER_BIT = 67
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       ready,
  output logic       active,
  output logic       tx
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] CLK_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [3:0]    BIT_LAST = 4'd9;

  logic          act_q, act_d;
  logic [9:0]    sh_q, sh_d;
  logic [3:0]    bit_q, bit_d;
  logic [CW-1:0] clk_q, clk_d;
  logic          bit_end, char_end;

  always_comb begin
    bit_end  = (clk_q == CLK_LAST);
    char_end = bit_end && (bit_q == BIT_LAST);
    act_d = act_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    clk_d = clk_q;
    if (load) begin
      act_d = 1'b1;
      sh_d  = {1'b1, data, 1'b0};
      bit_d = '0;
      clk_d = '0;
    end else if (act_q) begin
      if (bit_end) begin
        clk_d = '0;
        if (bit_q == BIT_LAST) begin
          act_d = 1'b0;
        end else begin
          sh_d  = {1'b1, sh_q[9:1]};
          bit_d = bit_q + 4'd1;
        end
      end else begin
        clk_d = clk_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sh_q  <= '1;
      bit_q <= '0;
      clk_q <= '0;
    end else begin
      act_q <= act_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
      clk_q <= clk_d;
    end
  end

  assign ready  = !act_q || char_end;
  assign active = act_q;
  assign tx     = act_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/spm_sender_ctrl.sv
module spm_sender_ctrl
  import spm_pkg::*;
#(
  parameter int SEND_BINS = 601,
  parameter int DEPTH     = 1200,
  parameter int MAG_W     = 12,
  parameter int EXP_W     = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_full,
  input  logic [EXP_W-1:0]  exp_q,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic              mag_valid,
  input  logic [MAG_W-1:0]  mag,
  input  logic              tx_ready,
  input  logic              tx_active,
  output logic              load,
  output logic [CHAR_W-1:0] char_o,
  output logic              release_o
);
  localparam int BW = $clog2(SEND_BINS + 1);
  localparam logic [BW-1:0] SEND_P = BW'(SEND_BINS);
  localparam logic [BW-1:0] LAST_P = BW'(SEND_BINS - 1);

  ctrl_state_e       state_q, state_d;
  tx_phase_e         phase_q, phase_d;
  logic [BW-1:0]     fetch_q, fetch_d;
  logic [BW-1:0]     bin_q, bin_d;
  logic              flight_q, flight_d;
  logic              mfull_q, mfull_d;
  logic [MAG_W-1:0]  mag_q, mag_d;
  logic [CHAR_W-1:0] lo_q, lo_d;
  logic              char_valid, sending;

  always_comb begin
    sending = (state_q == CT_SEND);
    rd_en   = sending && !mfull_q && !flight_q && (fetch_q < SEND_P);
    rd_addr = AW'(fetch_q);
    case (phase_q)
      PH_EXP:  begin char_valid = 1'b1;    char_o = CHAR_W'(exp_q);       end
      PH_HI:   begin char_valid = mfull_q; char_o = CHAR_W'(mag_q >> 8);  end
      PH_LO:   begin char_valid = 1'b1;    char_o = lo_q;                 end
      default: begin char_valid = 1'b0;    char_o = '0;                   end
    endcase
    load = sending && char_valid && tx_ready;

    state_d   = state_q;
    phase_d   = phase_q;
    fetch_d   = fetch_q;
    bin_d     = bin_q;
    flight_d  = flight_q;
    mfull_d   = mfull_q;
    mag_d     = mag_q;
    lo_d      = lo_q;
    release_o = 1'b0;

    if (!sending) begin
      if (frame_full) begin
        state_d  = CT_SEND;
        phase_d  = PH_EXP;
        fetch_d  = '0;
        bin_d    = '0;
        flight_d = 1'b0;
        mfull_d  = 1'b0;
      end
    end else begin
      if (rd_en) begin
        fetch_d  = fetch_q + BW'(1);
        flight_d = 1'b1;
      end
      if (mag_valid) begin
        mag_d    = mag;
        mfull_d  = 1'b1;
        flight_d = 1'b0;
      end
      if (load) begin
        case (phase_q)
          PH_EXP: phase_d = PH_HI;
          PH_HI: begin
            phase_d = PH_LO;
            lo_d    = CHAR_W'(mag_q);
            mfull_d = 1'b0;
          end
          PH_LO: begin
            phase_d = (bin_q == LAST_P) ? PH_END : PH_HI;
            bin_d   = bin_q + BW'(1);
          end
          default: phase_d = phase_q;
        endcase
      end
      if (phase_q == PH_END && !tx_active) begin
        state_d   = CT_IDLE;
        release_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CT_IDLE;
      phase_q  <= PH_EXP;
      fetch_q  <= '0;
      bin_q    <= '0;
      flight_q <= 1'b0;
      mfull_q  <= 1'b0;
      mag_q    <= '0;
      lo_q     <= '0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      fetch_q  <= fetch_d;
      bin_q    <= bin_d;
      flight_q <= flight_d;
      mfull_q  <= mfull_d;
      mag_q    <= mag_d;
      lo_q     <= lo_d;
    end
  end

  // R8: a root result never lands on a magnitude still waiting to be sent
  assert_mag_not_overwritten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mag_valid |-> !mfull_q);

  // R10: every sent bin was fetched, and no more, before the frame closes
  assert_all_fetched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && phase_q == PH_END) |-> (fetch_q == SEND_P && !flight_q));
endmodule

// File: rtl/spec_mag_sender.sv
module spec_mag_sender #(
  parameter int DEPTH        = 1200,
  parameter int SEND_BINS    = 601,
  parameter int DATA_W       = 16,
  parameter int MAG_W        = 12,
  parameter int EXP_W        = 4,
  parameter int CLKS_PER_BIT = 67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xf_valid,
  input  logic              xf_last,
  input  logic [DATA_W-1:0] xf_re,
  input  logic [DATA_W-1:0] xf_im,
  input  logic [EXP_W-1:0]  xf_exp,
  output logic              tx,
  output logic              busy
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic              rd_en, rd_valid, release_w, frame_full;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_re, rd_im;
  logic [EXP_W-1:0]  exp_q;
  logic              mag_valid;
  logic [MAG_W-1:0]  mag;
  logic              tx_ready, tx_active, load;
  logic [7:0]        char_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  spm_frame_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .EXP_W(EXP_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(xf_valid), .in_last(xf_last), .in_re(xf_re), .in_im(xf_im), .in_exp(xf_exp),
    .release_i(release_w), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_re(rd_re), .rd_im(rd_im), .rd_valid(rd_valid), .exp_q(exp_q), .full(frame_full)
  );

  spm_isqrt #(.IN_W(DATA_W), .OUT_W(MAG_W)) u_root (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(rd_valid),
    .in_re(rd_re), .in_im(rd_im), .out_valid(mag_valid), .out_mag(mag)
  );

  spm_sender_ctrl #(.SEND_BINS(SEND_BINS), .DEPTH(DEPTH), .MAG_W(MAG_W), .EXP_W(EXP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .frame_full(frame_full), .exp_q(exp_q),
    .rd_en(rd_en), .rd_addr(rd_addr), .mag_valid(mag_valid), .mag(mag),
    .tx_ready(tx_ready), .tx_active(tx_active), .load(load), .char_o(char_w),
    .release_o(release_w)
  );

  spm_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_uart (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .data(char_w),
    .ready(tx_ready), .active(tx_active), .tx(tx)
  );

  assign busy = frame_full;

  // R9: the line is idle when a frame is taken in
  assert_line_idle_at_rise_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> tx);

  // R9: the line is idle when the block lets go of a frame
  assert_line_idle_at_fall_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> (tx && !tx_active));
endmodule

// File: tb/spec_mag_sender_tb.sv
`timescale 1ns/1ps
module spec_mag_sender_tb;
  localparam int DEPTH = 20;
  localparam int SEND  = 11;
  localparam int CPB   = 4;
  localparam int NCHAR = 1 + 2 * SEND;
  localparam int TOTAL = NCHAR * 10 * CPB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xf_valid = 1'b0, xf_last = 1'b0;
  logic [15:0] xf_re = '0, xf_im = '0;
  logic [3:0]  xf_exp = '0;
  logic tx, busy;

  int checks = 0, fails = 0;
  int cyc = 0;
  int last_cyc = 0;
  int mode = 0, pos = 0, tail = 0, done_cnt = 0;
  bit pending = 1'b0, mon_on = 1'b0;
  int exp_chars [NCHAR];
  int fre [DEPTH];
  int fim [DEPTH];
  logic [7:0] rxb;

  spec_mag_sender #(.DEPTH(DEPTH), .SEND_BINS(SEND), .DATA_W(16), .MAG_W(12),
                    .EXP_W(4), .CLKS_PER_BIT(CPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .xf_valid(xf_valid), .xf_last(xf_last),
    .xf_re(xf_re), .xf_im(xf_im), .xf_exp(xf_exp), .tx(tx), .busy(busy));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  function automatic int ref_mag(input int re, input int im);
    longint s, r;
    s = longint'(re) * re + longint'(im) * im;
    r = longint'($sqrt(real'(s)));
    while (r * r > s) r--;
    while ((r + 1) * (r + 1) <= s) r++;
    if (r > 4095) r = 4095;
    return int'(r);
  endfunction

  task automatic fill(input int kind);
    int pre [11] = '{3, -3, 0, 4095, 4096, -32768, 2895, 1, 100, 0, 7};
    int pim [11] = '{4, -4, 0, 0, 0, -32768, -2896, 1, -200, -1, 24};
    for (int i = 0; i < DEPTH; i++) begin
      if (kind == 0) begin
        fre[i] = (i < 11) ? pre[i] : 30000;
        fim[i] = (i < 11) ? pim[i] : -30000 + i;
      end else if (kind == 1) begin
        fre[i] = ((i * 1237) % 6000) - 3000;
        fim[i] = ((i * 911) % 5000) - 2500;
      end else begin
        fre[i] = 2000 - 300 * i;
        fim[i] = i * i * 50 - 1000;
      end
    end
  endtask

  // drives one frame; gap inserts idle cycles between beats (R2)
  task automatic send_frame(input int expv, input bit gap);
    exp_chars[0] = expv;
    for (int b = 0; b < SEND; b++) begin
      exp_chars[1 + 2 * b] = ref_mag(fre[b], fim[b]) >> 8;
      exp_chars[2 + 2 * b] = ref_mag(fre[b], fim[b]) & 255;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (gap && (i % 3 == 1)) begin
        @(posedge clk); #1;
        xf_valid = 1'b0; xf_last = 1'b1; xf_exp = 4'hA;
      end
      @(posedge clk); #1;
      xf_valid = 1'b1;
      xf_re = 16'(fre[i]);
      xf_im = 16'(fim[i]);
      xf_last = (i == DEPTH - 1);
      xf_exp = (i == DEPTH - 1) ? 4'(expv) : 4'(i + 3);
      if (i == DEPTH - 1) begin
        last_cyc = cyc;
        pending = 1'b1;
      end
    end
    @(posedge clk); #1;
    xf_valid = 1'b0; xf_last = 1'b0;
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy after closing beat", int'(busy), 1);
  endtask

  task automatic junk_beats(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      xf_valid = 1'b1;
      xf_re = 16'(i * 777);
      xf_im = 16'(-i * 55);
      xf_exp = 4'(i);
      xf_last = (i % 7 == 6);
    end
    @(posedge clk); #1;
    xf_valid = 1'b0; xf_last = 1'b0;
  endtask

  task automatic stream_step;
    int cidx, bpos, ebit;
    cidx = pos / (10 * CPB);
    bpos = (pos / CPB) % 10;
    ebit = (bpos == 0) ? 0 : (bpos == 9) ? 1 : ((exp_chars[cidx] >> (bpos - 1)) & 1);
    if (bpos == 0 || bpos == 9) chk(tx === 1'(ebit), "R7 framing bit", int'(tx), ebit);
    else                        chk(tx === 1'(ebit), "R8 continuous data bit", int'(tx), ebit);
    chk(busy === 1'b1, "R9 busy during frame", int'(busy), 1);
    if (pos % CPB == CPB / 2) begin
      if (bpos >= 1 && bpos <= 8) rxb[bpos - 1] = tx;
      if (bpos == 9) begin
        if (cidx == 0) chk(int'(rxb) == exp_chars[0], "R5 exponent char", int'(rxb), exp_chars[0]);
        else           chk(int'(rxb) == exp_chars[cidx], "R6 magnitude char", int'(rxb), exp_chars[cidx]);
      end
    end
    pos++;
    if (pos == TOTAL) begin
      mode = 2;
      tail = 0;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      case (mode)
        0: begin
          if (tx === 1'b0) begin
            if (pending) begin
              chk(cyc - last_cyc <= 4, "R4 start latency", cyc - last_cyc, 4);
              pending = 1'b0;
              mode = 1;
              pos = 0;
              stream_step();
            end else begin
              chk(1'b0, "R3 spurious transmission", 0, 1);
            end
          end else begin
            chk(tx === 1'b1, "R9 idle line high", int'(tx), 1);
            if (pending && (cyc - last_cyc > 6)) begin
              chk(1'b0, "R4 no start bit", cyc - last_cyc, 4);
              pending = 1'b0;
            end
          end
        end
        1: stream_step();
        default: begin
          if (tail == 0) chk(tx === 1'b1, "R10 no extra character", int'(tx), 1);
          if (tail == 1) begin
            chk(busy === 1'b0, "R9 busy released", int'(busy), 0);
            mode = 0;
            done_cnt++;
          end
          tail++;
        end
      endcase
    end
  end

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx === 1'b1, "R1 tx in reset", int'(tx), 1);
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R1 idle after reset", int'({tx, busy}), 2);
    mon_on = 1'b1;

    // frame A: exact roots, saturation, rounding edge, unsent bins (R6, R10)
    fill(0);
    send_frame(5, 1'b0);
    wait (done_cnt == 1);
    repeat (5) @(posedge clk);

    // frame B: gaps between beats, then beats while busy (R2, R3)
    fill(1);
    send_frame(9, 1'b1);
    junk_beats(30);
    wait (done_cnt == 2);
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R3 no frame from ignored beats", int'(busy), 0);

    // frame C: largest exponent, different pattern (R5)
    fill(2);
    send_frame(15, 1'b0);
    wait (done_cnt == 3);
    repeat (5) @(posedge clk);
    summary();
  end
endmodule